// File: doc/BRIEF.md
# Block-Mode DMA Channel

This block is a single DMA channel that carries 16-bit half-words between a peripheral-side FIFO and system memory. It always moves whole blocks of 64 bytes. Each block is a burst of sixteen 32-bit words. The memory side uses a plain request/grant word interface. Software sees six registers through a small register port: a load address, a read-only current address, a block count, a mode/status word, a diagnostic word and the FIFO data port.

Software sets the load address and the block count, then writes the mode word to choose the direction, auto-reload and the interrupt enable. The channel starts a block whenever the FIFO level allows one. When the count runs out it either stops or reloads itself and keeps going. The channel stops with an error when the next block would start on a 512 KiB boundary while blocks remain.

Top module: `dma_block_channel`

## Requirements
- R1: After reset, the mode word reads 0x0000_0400 (only the empty bit, bit 10, is set). The diagnostic word reads 0, `irq` is low and `mem_req` is low.
- R2: Register select 5 is the FIFO port. A write pushes `reg_wdata[15:0]` and a read pops the oldest half-word, in first-in first-out order. Mode bits 7:0 give the occupancy. Bit 11 is set at 64 entries and bit 10 at 0 entries. A write while full is ignored, and a read while empty returns 0 and changes nothing.
- R3: A mode write with bit 31 set empties the FIFO.
- R4: With bit 27 set (into memory), a block starts only when the FIFO holds at least 32 half-words. The block is 16 write requests, and each word is {second half-word, first half-word}.
- R5: With bit 27 clear (out of memory), a block starts only when the FIFO holds at most 32 half-words. The block is 16 read requests, and the low half of each read word is pushed first.
- R6: Select 0 is the load address and select 1 the current address. A write to the load address clears the low 6 bits and copies the value into the current address. The current address advances by 4 per granted word. A write to select 1 has no effect.
- R7: `mem_req` and `mem_addr` hold steady until `mem_gnt` is seen.
- R8: Select 2 is the block count, which drops by one per finished block. When it reaches 0 without auto-reload, enable (bit 30) clears and no further requests are made.
- R9: With auto-reload (bit 29) at terminal count, the current address is reloaded from the load address and the count from the last written value, and blocks continue.
- R10: At terminal count with bit 28 set, interrupt pending (bit 8) and `irq` rise. They stay set until a mode write with bit 30 or bit 26 set, or until bit 28 is written 0.
- R11: If a block ends with the current address on a 2^19-byte multiple and the count non-zero, the error bit (bit 9) sets, enable clears and no requests follow. A mode write with bit 26 clears the error. A block that ends at terminal count raises no error.
- R12: While a block is in progress, a register FIFO access of the kind the DMA is doing (a push when out of memory, a pop when into memory) is dropped.
- R13: With enable clear, no block starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select (0 load, 1 current, 2 count, 3 mode, 4 diag, 5 FIFO) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO on select 5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on the select |
| irq | output | 1 | Interrupt pending |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with grant |
| mem_gnt | input | 1 | Grant, completes the current word |

## Verification
Some rules are checked by assertions on every cycle. The request holds with a stable address until grant, and the address steps by 4 inside a block. A block starts only at the FIFO level its direction requires, and no request is made while the error flag is set. The FIFO never overflows or underflows, which is the rule that makes the dropping of competing register accesses necessary. Other behaviour only shows in the bench scenarios: the half-word order inside memory words, the effect of auto-reload on the address and count registers, how long the interrupt persists and what clears it, and which side of the 512 KiB boundary raises the error.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    // Mode word: control bits written by software
    localparam int MODE_CLR_FIFO = 31;
    localparam int MODE_EN       = 30;
    localparam int MODE_AR       = 29;
    localparam int MODE_IE       = 28;
    localparam int MODE_DIR      = 27;
    localparam int MODE_CLR_ERR  = 26;
    // Mode word: status bits reported on read
    localparam int ST_FULL       = 11;
    localparam int ST_EMPTY      = 10;
    localparam int ST_ERR        = 9;
    localparam int ST_IRQ        = 8;

    typedef enum logic [2:0] {
        SEL_LOAD = 3'd0,
        SEL_CUR  = 3'd1,
        SEL_BLK  = 3'd2,
        SEL_MODE = 3'd3,
        SEL_DIAG = 3'd4,
        SEL_FIFO = 3'd5
    } reg_sel_e;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_BURST = 1'b1
    } eng_state_e;
endpackage

// File: rtl/dmach_fifo.sv
module dmach_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       push_n,
    input  logic [DW-1:0]    push_lo,
    input  logic [DW-1:0]    push_hi,
    input  logic [1:0]       pop_n,
    output logic [DW-1:0]    head0,
    output logic [DW-1:0]    head1,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0]    wptr;
        logic [PW-1:0]    rptr;
        logic [CNT_W-1:0] count;
    } fifo_t;

    fifo_t q, d;
    logic [DW-1:0] store_q [DEPTH];

    always_comb begin
        d       = q;
        d.wptr  = q.wptr + PW'(push_n);
        d.rptr  = q.rptr + PW'(pop_n);
        d.count = q.count + CNT_W'(push_n) - CNT_W'(pop_n);
        if (clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && push_n != 2'd0) begin
            store_q[q.wptr] <= push_lo;
        end
        if (!clr && push_n == 2'd2) begin
            store_q[q.wptr + PW'(1)] <= push_hi;
        end
    end

    assign head0 = store_q[q.rptr];
    assign head1 = store_q[q.rptr + PW'(1)];
    assign count = q.count;
    assign full  = (q.count == CNT_W'(DEPTH));
    assign empty = (q.count == '0);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(DEPTH));
    p_push_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (32'(q.count) + 32'(push_n) <= DEPTH));
    p_pop_avail_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (32'(pop_n) <= 32'(q.count)));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLK_W      = 16,
    parameter int BEATS      = 16,
    parameter int BOUND_BITS = 19,
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int BEAT_W     = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_blk,
    input  logic              wr_mode,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] laddr,
    output logic [ADDR_W-1:0] caddr,
    output logic [BLK_W-1:0]  blk,
    output logic              en,
    output logic              ar,
    output logic              ie,
    output logic              dir,
    output logic              err,
    output logic              irq,
    output logic [BEAT_W-1:0] beat,
    output logic              dma_pop,
    output logic              dma_push
);
    localparam int ALIGN  = $clog2(BEATS * 4);
    localparam int HALVES = BEATS * 2;

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] laddr;
        logic [ADDR_W-1:0] caddr;
        logic [BLK_W-1:0]  blk;
        logic [BLK_W-1:0]  shadow;
        logic              en;
        logic              ar;
        logic              ie;
        logic              dir;
        logic              err;
        logic              irq;
        logic [BEAT_W-1:0] beat;
    } eng_t;

    eng_t q, d;

    logic [ADDR_W-1:0] next_addr;
    logic [BLK_W-1:0]  blk_left;
    logic              start_ok;
    logic              last_beat;

    assign next_addr = q.caddr + ADDR_W'(4);
    assign blk_left  = q.blk - BLK_W'(1);
    assign last_beat = (q.beat == BEAT_W'(BEATS - 1));
    assign start_ok  = q.dir ? (fifo_count >= CNT_W'(HALVES))
                             : (fifo_count <= CNT_W'(FIFO_DEPTH - HALVES));

    always_comb begin
        d        = q;
        dma_pop  = 1'b0;
        dma_push = 1'b0;

        if (wr_load && q.st == ENG_IDLE) begin
            d.laddr = {wdata[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
            d.caddr = d.laddr;
        end
        if (wr_blk && q.st == ENG_IDLE) begin
            d.blk    = wdata[BLK_W-1:0];
            d.shadow = wdata[BLK_W-1:0];
        end
        if (wr_mode) begin
            d.en = wdata[MODE_EN];
            d.ar = wdata[MODE_AR];
            d.ie = wdata[MODE_IE];
            if (q.st == ENG_IDLE) begin
                d.dir = wdata[MODE_DIR];
            end
            if (wdata[MODE_CLR_ERR]) begin
                d.err = 1'b0;
            end
            if (wdata[MODE_EN] || wdata[MODE_CLR_ERR]) begin
                d.irq = 1'b0;
            end
        end

        unique case (q.st)
            ENG_IDLE: begin
                if (q.en && !q.err && q.blk != '0 && start_ok) begin
                    d.st   = ENG_BURST;
                    d.beat = '0;
                end
            end
            ENG_BURST: begin
                if (mem_gnt) begin
                    dma_pop  = q.dir;
                    dma_push = !q.dir;
                    d.caddr  = next_addr;
                    d.beat   = q.beat + BEAT_W'(1);
                    if (last_beat) begin
                        d.st  = ENG_IDLE;
                        d.blk = blk_left;
                        if (blk_left == '0) begin
                            if (q.ie) begin
                                d.irq = 1'b1;
                            end
                            if (q.ar) begin
                                d.caddr = q.laddr;
                                d.blk   = q.shadow;
                            end else begin
                                d.en = 1'b0;
                            end
                        end else if (next_addr[BOUND_BITS-1:0] == '0) begin
                            d.err = 1'b1;
                            d.en  = 1'b0;
                        end
                    end
                end
            end
            default: d.st = ENG_IDLE;
        endcase

        if (!d.ie) begin
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st == ENG_BURST);
    assign mem_we   = q.dir;
    assign mem_addr = q.caddr;
    assign laddr    = q.laddr;
    assign caddr    = q.caddr;
    assign blk      = q.blk;
    assign en       = q.en;
    assign ar       = q.ar;
    assign ie       = q.ie;
    assign dir      = q.dir;
    assign err      = q.err;
    assign irq      = q.irq;
    assign beat     = q.beat;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && !last_beat |=> mem_addr == $past(mem_addr) + ADDR_W'(4));
    p_start_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> $past(fifo_count) >= CNT_W'(HALVES));
    p_start_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> $past(fifo_count) <= CNT_W'(FIFO_DEPTH - HALVES));
    p_irq_at_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_gnt) && $past(mem_req));
    p_err_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel
    import dmach_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLK_W      = 16,
    parameter int FIFO_DEPTH = 64,
    parameter int BEATS      = 16,
    parameter int BOUND_BITS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_gnt
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int BEAT_W = $clog2(BEATS);

    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_full, fifo_empty;
    logic [15:0]       head0, head1;
    logic [ADDR_W-1:0] laddr, caddr;
    logic [BLK_W-1:0]  blk;
    logic              en, ar, ie, dir, err;
    logic [BEAT_W-1:0] beat;
    logic              dma_pop, dma_push;
    logic              sel_fifo, sel_mode;
    logic              reg_push, reg_pop, fifo_clr;
    logic [1:0]        push_n, pop_n;
    logic [15:0]       push_lo;
    logic [31:0]       mode_word;

    assign sel_fifo = (reg_sel_e'(reg_sel) == SEL_FIFO);
    assign sel_mode = (reg_sel_e'(reg_sel) == SEL_MODE);

    // Competing register accesses are dropped while a block is in flight
    assign reg_push = reg_wr && sel_fifo && !fifo_full  && !(mem_req && !dir);
    assign reg_pop  = reg_rd && sel_fifo && !fifo_empty && !(mem_req && dir);
    assign fifo_clr = reg_wr && sel_mode && reg_wdata[MODE_CLR_FIFO];

    assign push_n  = dma_push ? 2'd2 : (reg_push ? 2'd1 : 2'd0);
    assign pop_n   = dma_pop  ? 2'd2 : (reg_pop  ? 2'd1 : 2'd0);
    assign push_lo = dma_push ? mem_rdata[15:0] : reg_wdata[15:0];

    dmach_fifo #(
        .DW    (16),
        .DEPTH (FIFO_DEPTH),
        .CNT_W (CNT_W)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .push_n  (push_n),
        .push_lo (push_lo),
        .push_hi (mem_rdata[31:16]),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1),
        .count   (fifo_count),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    dmach_engine #(
        .ADDR_W     (ADDR_W),
        .BLK_W      (BLK_W),
        .BEATS      (BEATS),
        .BOUND_BITS (BOUND_BITS),
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W),
        .BEAT_W     (BEAT_W)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_load    (reg_wr && reg_sel_e'(reg_sel) == SEL_LOAD),
        .wr_blk     (reg_wr && reg_sel_e'(reg_sel) == SEL_BLK),
        .wr_mode    (reg_wr && sel_mode),
        .wdata      (reg_wdata),
        .fifo_count (fifo_count),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .laddr      (laddr),
        .caddr      (caddr),
        .blk        (blk),
        .en         (en),
        .ar         (ar),
        .ie         (ie),
        .dir        (dir),
        .err        (err),
        .irq        (irq),
        .beat       (beat),
        .dma_pop    (dma_pop),
        .dma_push   (dma_push)
    );

    assign mem_wdata = {head1, head0};

    always_comb begin
        mode_word               = '0;
        mode_word[MODE_EN]      = en;
        mode_word[MODE_AR]      = ar;
        mode_word[MODE_IE]      = ie;
        mode_word[MODE_DIR]     = dir;
        mode_word[ST_FULL]      = fifo_full;
        mode_word[ST_EMPTY]     = fifo_empty;
        mode_word[ST_ERR]       = err;
        mode_word[ST_IRQ]       = irq;
        mode_word[7:0]          = 8'(fifo_count);
    end

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_LOAD: reg_rdata = 32'(laddr);
            SEL_CUR:  reg_rdata = 32'(caddr);
            SEL_BLK:  reg_rdata = 32'(blk);
            SEL_MODE: reg_rdata = mode_word;
            SEL_DIAG: reg_rdata = 32'({mem_req, beat});
            SEL_FIFO: reg_rdata = fifo_empty ? 32'd0 : 32'(head0);
            default:  reg_rdata = '0;
        endcase
    end

    p_no_req_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(en));
endmodule

// File: tb/test_dma_block_channel.sv
`timescale 1ns/1ps
module test_dma_block_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  gcnt = '0;

    int total = 0, bad = 0;
    int nlog = 0;
    logic [31:0] log_addr [128];
    logic [31:0] log_data [128];
    logic        log_we   [128];

    always #4 clk = ~clk;

    always @(posedge clk) gcnt <= gcnt + 8'd1;
    assign mem_gnt   = mem_req && gcnt[0];
    assign mem_rdata = {mem_addr[15:0] ^ 16'h5A5A, mem_addr[15:0]};

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt && nlog < 128) begin
            log_addr[nlog] = mem_addr;
            log_data[nlog] = mem_wdata;
            log_we[nlog]   = mem_we;
            nlog = nlog + 1;
        end
    end

    dma_block_channel i_dma_block_channel (
        .clk, .rst_n, .reg_sel, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
        .irq, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_gnt
    );

    localparam logic [2:0] S_LOAD = 3'd0, S_CUR = 3'd1, S_BLK = 3'd2,
                           S_MODE = 3'd3, S_DIAG = 3'd4, S_FIFO = 3'd5;

    typedef struct packed {
        logic        is_pop;
        logic [15:0] data;
        logic [15:0] exp_data;
        logic [7:0]  exp_cnt;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, 16'hA001, 16'h0000, 8'd1},
        '{1'b0, 16'hB002, 16'h0000, 8'd2},
        '{1'b0, 16'hC003, 16'h0000, 8'd3},
        '{1'b1, 16'h0000, 16'hA001, 8'd2},
        '{1'b0, 16'hD004, 16'h0000, 8'd3},
        '{1'b1, 16'h0000, 16'hB002, 8'd2},
        '{1'b1, 16'h0000, 16'hC003, 8'd1},
        '{1'b1, 16'h0000, 16'hD004, 8'd0},
        '{1'b1, 16'h0000, 16'h0000, 8'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 200 && !mem_req; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        run(3);
        rst_n = 1'b1;
        run(2);

        // R1 reset state
        rd(S_MODE, v); chk("R1 mode", v, 32'h0000_0400);
        rd(S_DIAG, v); chk("R1 diag", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 req", {31'b0, mem_req}, 32'h0);

        // R2 vector walk through the FIFO port
        foreach (VEC[i]) begin
            if (VEC[i].is_pop) begin
                rd(S_FIFO, v);
                chk("R2 fifo data", v, 32'(VEC[i].exp_data));
            end else begin
                wr(S_FIFO, 32'(VEC[i].data));
            end
            rd(S_MODE, v);
            chk("R2 fifo count", 32'(v[7:0]), 32'(VEC[i].exp_cnt));
        end

        // R2 full flag, write-while-full ignored; R3 clear
        for (int i = 0; i < 65; i++) wr(S_FIFO, 32'(16'h0E00 + i));
        rd(S_MODE, v); chk("R2 full", v, 32'h0000_0840);
        rd(S_FIFO, v); chk("R2 head after overfill", v, 32'h0000_0E00);
        wr(S_MODE, 32'h8000_0000);
        rd(S_MODE, v); chk("R3 cleared", v, 32'h0000_0400);

        // R6 address alignment, read-only current address
        wr(S_LOAD, 32'h1000_0047);
        rd(S_LOAD, v); chk("R6 load aligned", v, 32'h1000_0040);
        rd(S_CUR, v);  chk("R6 current copied", v, 32'h1000_0040);
        wr(S_CUR, 32'h0);
        rd(S_CUR, v);  chk("R6 current read-only", v, 32'h1000_0040);

        // R4 into memory: waits for 32 half-words
        wr(S_BLK, 32'd2);
        for (int i = 0; i < 20; i++) wr(S_FIFO, 32'(16'h0100 + i));
        wr(S_MODE, 32'h5800_0000);
        run(40);
        chk("R4 no start below level", 32'(nlog), 32'd0);
        for (int i = 20; i < 32; i++) wr(S_FIFO, 32'(16'h0100 + i));
        run(60);
        chk("R4 block words", 32'(nlog), 32'd16);
        for (int k = 0; k < 16; k++) begin
            chk("R6 write address", log_addr[k], 32'h1000_0040 + 32'(4 * k));
            chk("R4 word packing", log_data[k],
                {16'(16'h0100 + 2 * k + 1), 16'(16'h0100 + 2 * k)});
            chk("R4 direction", {31'b0, log_we[k]}, 32'h1);
        end
        rd(S_BLK, v); chk("R8 count after block", v, 32'd1);
        rd(S_CUR, v); chk("R6 current advanced", v, 32'h1000_0080);
        chk("R10 no irq before tc", {31'b0, irq}, 32'h0);

        // Second block; R12 software pop during burst is dropped
        for (int i = 0; i < 32; i++) wr(S_FIFO, 32'(16'h0200 + i));
        wait_req();
        rd(S_FIFO, v);
        run(60);
        chk("R8 total words", 32'(nlog), 32'd32);
        for (int k = 0; k < 16; k++) begin
            chk("R12 data intact", log_data[16 + k],
                {16'(16'h0200 + 2 * k + 1), 16'(16'h0200 + 2 * k)});
        end
        rd(S_MODE, v); chk("R8 R10 terminal status", v, 32'h1800_0500);
        chk("R10 irq out", {31'b0, irq}, 32'h1);
        rd(S_BLK, v); chk("R8 count zero", v, 32'd0);
        run(20);
        chk("R8 no more requests", 32'(nlog), 32'd32);
        wr(S_MODE, 32'h1800_0000);
        chk("R10 irq persists", {31'b0, irq}, 32'h1);
        wr(S_MODE, 32'h1400_0000);
        chk("R10 clear-error bit clears irq", {31'b0, irq}, 32'h0);

        // R5 R9 out of memory with auto-reload; R12 push during burst dropped
        wr(S_MODE, 32'h8000_0000);
        wr(S_LOAD, 32'h2000_0000);
        wr(S_BLK, 32'd1);
        wr(S_MODE, 32'h7000_0000);
        wait_req();
        wr(S_FIFO, 32'h0000_DEAD);
        run(150);
        chk("R5 R9 read words", 32'(nlog), 32'd64);
        for (int k = 0; k < 32; k++) begin
            chk("R9 reload address", log_addr[32 + k], 32'h2000_0000 + 32'(4 * (k % 16)));
            chk("R5 direction", {31'b0, log_we[32 + k]}, 32'h0);
        end
        rd(S_MODE, v); chk("R5 R9 R12 status", v, 32'h7000_0940);
        rd(S_CUR, v);  chk("R9 current reloaded", v, 32'h2000_0000);
        rd(S_BLK, v);  chk("R9 count reloaded", v, 32'd1);
        rd(S_FIFO, v); chk("R5 low half first", v, 32'h0000_0000);
        rd(S_FIFO, v); chk("R5 high half second", v, 32'h0000_5A5A);
        rd(S_FIFO, v); chk("R5 next word low", v, 32'h0000_0004);
        rd(S_FIFO, v); chk("R5 next word high", v, 32'h0000_5A5E);
        wr(S_MODE, 32'h2000_0000);
        chk("R10 ie clear drops irq", {31'b0, irq}, 32'h0);
        rd(S_MODE, v); chk("R10 status after ie clear", v, 32'h2000_003C);

        // R13 disabled channel does not start
        base = nlog;
        wr(S_MODE, 32'h0800_0000);
        run(50);
        chk("R13 no start", 32'(nlog), 32'(base));

        // R11 boundary with blocks remaining
        wr(S_MODE, 32'h8800_0000);
        wr(S_LOAD, 32'h0007_FFC0);
        wr(S_BLK, 32'd3);
        for (int i = 0; i < 64; i++) wr(S_FIFO, 32'(16'h0300 + i));
        base = nlog;
        wr(S_MODE, 32'h4800_0000);
        run(120);
        chk("R11 one block only", 32'(nlog - base), 32'd16);
        chk("R11 last address", log_addr[base + 15], 32'h0007_FFFC);
        rd(S_MODE, v); chk("R11 error status", v, 32'h0800_0220);
        rd(S_CUR, v);  chk("R11 current at boundary", v, 32'h0008_0000);
        rd(S_BLK, v);  chk("R11 count left", v, 32'd2);
        wr(S_MODE, 32'h0C00_0000);
        rd(S_MODE, v); chk("R11 error cleared", v, 32'h0800_0020);

        // R11 boundary at terminal count raises no error
        wr(S_MODE, 32'h8800_0000);
        wr(S_LOAD, 32'h000F_FFC0);
        wr(S_BLK, 32'd1);
        for (int i = 0; i < 32; i++) wr(S_FIFO, 32'(16'h0400 + i));
        base = nlog;
        wr(S_MODE, 32'h4800_0000);
        run(80);
        chk("R11 tc block words", 32'(nlog - base), 32'd16);
        rd(S_MODE, v); chk("R11 no error at tc", v, 32'h0800_0400);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule